// File: doc/BRIEF.md
# Multi-Lane Vector Arithmetic Unit

This block runs one element-wise arithmetic instruction at a time on a small vector register file. There are sixteen vector registers. Each holds 32 elements, and each element is a 64-bit word. An instruction names an opcode, a destination register and two source registers. For every element index i, the unit combines element i of the first source with element i of the second source and writes the result to element i of the destination. No value crosses from one element position to another.

The datapath has eight physical lanes, each with its own slice of register storage. A 32-element vector therefore moves through the lanes in four beats. In beat k, lane j handles element k*8+j. The element storage reads with a one-cycle registered latency, so each beat is read in one cycle and written back in the next. A start/busy handshake admits an instruction, and a single-cycle done pulse marks its completion.

A side port writes and reads single elements while the unit is idle. It is used to load operands and to inspect results.

Top module: `vec_alu_unit`

## Requirements
- R1: After reset, busy and done are both low.
- R2: A start with a legal opcode, sampled at a clock edge while busy is low, raises busy at that edge. Busy stays high until the fifth edge after it. At that fifth edge busy falls, and done goes high for exactly one cycle.
- R3: Opcode 0 writes, for every index i, the sum modulo 2^64 of element i of the first source and element i of the second source.
- R4: Opcode 1 writes, for every index i, element i of the first source minus element i of the second source, modulo 2^64.
- R5: Opcodes 2, 3 and 4 write the bitwise AND, OR and XOR of the two sources, element by element.
- R6: Each destination element depends only on the source elements with the same index. Elements k*8+j are processed by lane j in beat k.
- R7: The destination register may be the same as either source, or as both, and the result equals the one computed from the source values before the instruction.
- R8: A start while busy is high has no effect on busy, on done or on any register.
- R9: A start with opcode 5, 6 or 7 is ignored. Busy stays low and no register changes.
- R10: When the side write enable is high and busy is low, the element selected by register index and element index (0 to 31) takes the write data at the clock edge. The side read data shows the element addressed at the previous edge.
- R11: A side write presented while busy is high is ignored.
- R12: An instruction changes no register other than its destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an instruction |
| op | input | 3 | Opcode: 0 add, 1 sub, 2 and, 3 or, 4 xor |
| vd | input | 4 | Destination register index |
| vs1 | input | 4 | First source register index |
| vs2 | input | 4 | Second source register index |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| sd_we | input | 1 | Side-port element write enable |
| sd_reg | input | 4 | Side-port register index |
| sd_elem | input | 5 | Side-port element index |
| sd_wdata | input | 64 | Side-port write data |
| sd_rdata | output | 64 | Side-port read data, one cycle after the address |

## Verification
Busy is due at the edge that accepts a start, and done and the falling edge of busy are due five edges after that. A behavioural model in the bench counts those five edges from its own copy of the handshake, and it compares busy and done with the design at every falling clock edge. Register contents are checked over the side port only once the model shows the unit idle. Each address is driven on one falling edge, and the read data is sampled on the next falling edge, one registered stage later.

// File: rtl/vec_pkg.sv
package vec_pkg;

  typedef enum logic [2:0] {
    VOP_ADD = 3'd0,
    VOP_SUB = 3'd1,
    VOP_AND = 3'd2,
    VOP_OR  = 3'd3,
    VOP_XOR = 3'd4
  } vop_e;

  function automatic logic op_legal(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

endpackage

// File: rtl/vec_bank.sv
module vec_bank #(
  parameter int W     = 64,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  q
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    q <= mem[ra];
  end

endmodule

// File: rtl/vec_lane.sv
module vec_lane
  import vec_pkg::*;
#(
  parameter int EW    = 64,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op,
  input  logic          alu_we,
  input  logic          side_we,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  input  logic [AW-1:0] wr_addr,
  input  logic [EW-1:0] side_wdata,
  output logic [EW-1:0] rdata_a
);

  logic [EW-1:0] qa, qb, res, wdata;
  logic          we;

  always_comb begin
    unique case (vop_e'(op))
      VOP_ADD: res = qa + qb;
      VOP_SUB: res = qa - qb;
      VOP_AND: res = qa & qb;
      VOP_OR:  res = qa | qb;
      VOP_XOR: res = qa ^ qb;
      default: res = '0;
    endcase
  end

  assign we      = alu_we | side_we;
  assign wdata   = alu_we ? res : side_wdata;
  assign rdata_a = qa;

  // Two copies of the lane storage, written identically, give two read ports.
  vec_bank #(.W(EW), .DEPTH(DEPTH), .AW(AW)) u_bank_a (
    .clk(clk), .we(we), .wa(wr_addr), .wd(wdata), .ra(rd_addr_a), .q(qa)
  );
  vec_bank #(.W(EW), .DEPTH(DEPTH), .AW(AW)) u_bank_b (
    .clk(clk), .we(we), .wa(wr_addr), .wd(wdata), .ra(rd_addr_b), .q(qb)
  );

  // R11: a side write never collides with a lane writeback
  p_side_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(alu_we && side_we));

endmodule

// File: rtl/vec_seq.sv
module vec_seq
  import vec_pkg::*;
#(
  parameter int RW    = 4,
  parameter int BW    = 2,
  parameter int BEATS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [RW-1:0] vd,
  input  logic [RW-1:0] vs1,
  input  logic [RW-1:0] vs2,
  output logic          busy,
  output logic          done,
  output logic [BW-1:0] rd_beat,
  output logic          wb_act,
  output logic [BW-1:0] wb_beat,
  output logic [2:0]    cur_op,
  output logic [RW-1:0] cur_vd,
  output logic [RW-1:0] cur_vs1,
  output logic [RW-1:0] cur_vs2
);

  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  logic rd_act;
  logic accept;

  assign accept = start && !busy && op_legal(op);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      rd_act  <= 1'b0;
      rd_beat <= '0;
      wb_act  <= 1'b0;
      wb_beat <= '0;
      cur_op  <= '0;
      cur_vd  <= '0;
      cur_vs1 <= '0;
      cur_vs2 <= '0;
    end else begin
      wb_act  <= rd_act;
      wb_beat <= rd_beat;
      done    <= wb_act && (wb_beat == LAST);
      if (wb_act && (wb_beat == LAST)) busy <= 1'b0;
      if (rd_act) begin
        rd_beat <= rd_beat + 1'b1;
        if (rd_beat == LAST) rd_act <= 1'b0;
      end
      if (accept) begin
        busy    <= 1'b1;
        rd_act  <= 1'b1;
        rd_beat <= '0;
        cur_op  <= op;
        cur_vd  <= vd;
        cur_vs1 <= vs1;
        cur_vs2 <= vs2;
      end
    end
  end

  // R2
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op_legal(op)) |=> busy);
  p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_fall_done_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R9
  p_illegal_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !op_legal(op)) |=> !busy);
  // R6: beats are issued in ascending order
  p_beat_order_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_act && $past(rd_act)) |-> (rd_beat == BW'($past(rd_beat) + 1'b1)));
  // R8: the instruction fields stay latched while busy
  p_hold_fields_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cur_vd));

endmodule

// File: rtl/vec_alu_unit.sv
module vec_alu_unit #(
  parameter int NREG  = 16,
  parameter int VLEN  = 32,
  parameter int EW    = 64,
  parameter int LANES = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [2:0]                op,
  input  logic [$clog2(NREG)-1:0]   vd,
  input  logic [$clog2(NREG)-1:0]   vs1,
  input  logic [$clog2(NREG)-1:0]   vs2,
  output logic                      busy,
  output logic                      done,
  input  logic                      sd_we,
  input  logic [$clog2(NREG)-1:0]   sd_reg,
  input  logic [$clog2(VLEN)-1:0]   sd_elem,
  input  logic [EW-1:0]             sd_wdata,
  output logic [EW-1:0]             sd_rdata
);

  localparam int BEATS = VLEN / LANES;
  localparam int RW    = $clog2(NREG);
  localparam int EIW   = $clog2(VLEN);
  localparam int LW    = $clog2(LANES);
  localparam int BW    = EIW - LW;
  localparam int AW    = RW + BW;
  localparam int DEPTH = NREG * BEATS;

  logic [BW-1:0] rd_beat, wb_beat;
  logic          wb_act;
  logic [2:0]    cur_op;
  logic [RW-1:0] cur_vd, cur_vs1, cur_vs2;

  logic [LW-1:0] sd_lane, rsel_q;
  logic [BW-1:0] sd_beat;
  logic [AW-1:0] addr_a, addr_b, addr_w;
  logic [EW-1:0] lane_q [LANES];

  assign sd_lane = sd_elem[LW-1:0];
  assign sd_beat = sd_elem[EIW-1:LW];

  assign addr_a = busy ? {cur_vs1, rd_beat} : {sd_reg, sd_beat};
  assign addr_b = {cur_vs2, rd_beat};
  assign addr_w = wb_act ? {cur_vd, wb_beat} : {sd_reg, sd_beat};

  vec_seq #(.RW(RW), .BW(BW), .BEATS(BEATS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .vd(vd), .vs1(vs1), .vs2(vs2),
    .busy(busy), .done(done), .rd_beat(rd_beat),
    .wb_act(wb_act), .wb_beat(wb_beat), .cur_op(cur_op),
    .cur_vd(cur_vd), .cur_vs1(cur_vs1), .cur_vs2(cur_vs2)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic side_we_l;
    assign side_we_l = sd_we && !busy && (sd_lane == LW'(l));

    vec_lane #(.EW(EW), .DEPTH(DEPTH), .AW(AW)) u_lane (
      .clk(clk), .rst(rst), .op(cur_op),
      .alu_we(wb_act), .side_we(side_we_l),
      .rd_addr_a(addr_a), .rd_addr_b(addr_b), .wr_addr(addr_w),
      .side_wdata(sd_wdata), .rdata_a(lane_q[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rsel_q <= '0;
    else     rsel_q <= sd_lane;
  end

  assign sd_rdata = lane_q[rsel_q];

  // R1
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!busy && !done));

endmodule

// File: tb/sim_vec_alu_unit.sv
module sim_vec_alu_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [2:0]  op;
  logic [3:0]  vd, vs1, vs2;
  logic        busy, done;
  logic        sd_we;
  logic [3:0]  sd_reg;
  logic [4:0]  sd_elem;
  logic [63:0] sd_wdata, sd_rdata;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  vec_alu_unit u0 (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .vd(vd), .vs1(vs1), .vs2(vs2), .busy(busy), .done(done),
    .sd_we(sd_we), .sd_reg(sd_reg), .sd_elem(sd_elem),
    .sd_wdata(sd_wdata), .sd_rdata(sd_rdata)
  );

  // Behavioural reference model
  logic [63:0] model [16][32];
  int          mcnt;
  logic        mbusy, mdone;
  logic [2:0]  mop;
  logic [3:0]  mvd, mvs1, mvs2;

  function automatic logic [63:0] apply_op(logic [2:0] o, logic [63:0] a, logic [63:0] b);
    case (o)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mcnt = 0; mbusy = 1'b0; mdone = 1'b0;
    end else begin
      if (sd_we && !mbusy) model[sd_reg][sd_elem] = sd_wdata;
      mdone = 1'b0;
      if (mcnt > 0) begin
        mcnt = mcnt - 1;
        if (mcnt == 0) begin
          logic [63:0] tmp [32];
          for (int i = 0; i < 32; i++) tmp[i] = apply_op(mop, model[mvs1][i], model[mvs2][i]);
          for (int i = 0; i < 32; i++) model[mvd][i] = tmp[i];
          mbusy = 1'b0;
          mdone = 1'b1;
        end
      end else if (start && op <= 3'd4) begin
        mop = op; mvd = vd; mvs1 = vs1; mvs2 = vs2;
        mcnt = 5; mbusy = 1'b1;
      end
    end
  end

  // R2: handshake compared on every clock
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (busy !== mbusy || done !== mdone) begin
        failures++;
        $display("FAIL R2 busy/done got %b/%b exp %b/%b", busy, done, mbusy, mdone);
      end
    end
  end

  task automatic side_wr(input logic [3:0] r, input logic [4:0] e, input logic [63:0] d);
    sd_we = 1'b1; sd_reg = r; sd_elem = e; sd_wdata = d;
    @(negedge clk);
    sd_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] r, input logic [4:0] e, input string tag);
    sd_reg = r; sd_elem = e;
    @(negedge clk);
    checks++;
    if (sd_rdata !== model[r][e]) begin
      failures++;
      $display("FAIL %s v%0d[%0d] got %h exp %h", tag, r, e, sd_rdata, model[r][e]);
    end
  endtask

  task automatic vec_chk(input logic [3:0] r, input string tag);
    for (int e = 0; e < 32; e++) rd_chk(r, 5'(e), tag);
  endtask

  task automatic issue(input logic [2:0] o, input logic [3:0] d, input logic [3:0] a, input logic [3:0] b);
    start = 1'b1; op = o; vd = d; vs1 = a; vs2 = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input logic [2:0] o, input logic [3:0] d, input logic [3:0] a, input logic [3:0] b);
    issue(o, d, a, b);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; op = '0; vd = '0; vs1 = '0; vs2 = '0;
    sd_we = 1'b0; sd_reg = '0; sd_elem = '0; sd_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    checks++;
    if (busy !== 1'b0 || done !== 1'b0) begin
      failures++;
      $display("FAIL R1 busy/done got %b/%b exp 0/0", busy, done);
    end

    // R10: load every register through the side port
    for (int r = 0; r < 16; r++)
      for (int e = 0; e < 32; e++)
        side_wr(4'(r), 5'(e), {32'(r * 977 + 5), 32'(e * 131 + r)});
    for (int e = 0; e < 32; e++) begin
      side_wr(4'd1, 5'(e), 64'hFFFF_FFFF_FFFF_FFF0 + 64'(e));
      side_wr(4'd2, 5'(e), 64'(e * 3 + 17));
      side_wr(4'd3, 5'(e), {32'(e), ~32'(e)});
    end
    vec_chk(4'd1, "R10");
    vec_chk(4'd3, "R10");

    run(3'd0, 4'd4, 4'd1, 4'd2);  vec_chk(4'd4, "R3 R6");
    run(3'd1, 4'd5, 4'd2, 4'd1);  vec_chk(4'd5, "R4");
    run(3'd2, 4'd6, 4'd1, 4'd3);  vec_chk(4'd6, "R5 and");
    run(3'd3, 4'd7, 4'd2, 4'd3);  vec_chk(4'd7, "R5 or");
    run(3'd4, 4'd8, 4'd1, 4'd3);  vec_chk(4'd8, "R5 xor");
    vec_chk(4'd3, "R12");
    vec_chk(4'd15, "R12");

    run(3'd0, 4'd1, 4'd1, 4'd2);  vec_chk(4'd1, "R7 vd=vs1");
    run(3'd1, 4'd2, 4'd3, 4'd2);  vec_chk(4'd2, "R7 vd=vs2");
    run(3'd4, 4'd3, 4'd3, 4'd3);  vec_chk(4'd3, "R7 all same");

    // R8: second start during busy is dropped
    issue(3'd0, 4'd9, 4'd4, 4'd5);
    issue(3'd1, 4'd10, 4'd4, 4'd5);
    repeat (6) @(negedge clk);
    vec_chk(4'd9, "R8 first op");
    vec_chk(4'd10, "R8 dropped op");

    // R9: illegal opcode ignored
    issue(3'd5, 4'd11, 4'd1, 4'd2);
    checks++;
    if (busy !== 1'b0) begin
      failures++;
      $display("FAIL R9 busy got %b exp 0", busy);
    end
    issue(3'd7, 4'd11, 4'd1, 4'd2);
    repeat (2) @(negedge clk);
    vec_chk(4'd11, "R9");

    // R11: side write while busy ignored
    issue(3'd2, 4'd13, 4'd4, 4'd8);
    side_wr(4'd12, 5'd3, 64'hDEAD_BEEF_0000_0001);
    side_wr(4'd12, 5'd30, 64'h1234_5678_9ABC_DEF0);
    repeat (5) @(negedge clk);
    rd_chk(4'd12, 5'd3, "R11");
    rd_chk(4'd12, 5'd30, "R11");
    vec_chk(4'd13, "R5 after R11");

    // R10: idle side write then read back
    side_wr(4'd12, 5'd31, 64'h0F0F_0000_FFFF_1111);
    rd_chk(4'd12, 5'd31, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule